// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

This block computes one integer operation per cycle on byte or word operands and keeps a six-bit status register that each operation updates under its own policy. The result is combinational from the inputs; the status register is loaded on the clock edge that ends a cycle in which `op_valid` is high. Arithmetic that chains across bytes (add with carry, subtract with borrow, decimal correction) reads the carry and auxiliary-carry bits that are in the register at that moment.

In byte mode (`wide` = 0) the operation works on bits 7:0 of the operands and the result passes bits 15:8 of `src_a` through unchanged, so a caller can treat the output as the updated 16-bit register. The three decimal-correction operations always work on the low byte and ignore `wide`. The status port packs the flags as bit 5 overflow, bit 4 sign, bit 3 zero, bit 2 half carry (carry or borrow out of bit 3), bit 1 parity, bit 0 carry.

Opcodes: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 increment, 6 decrement, 7 negate, 8 AND, 9 OR, 10 XOR, 11 NOT, 12 test, 13 decimal-adjust-after-add, 14 decimal-adjust-after-subtract, 15 unpacked-adjust-after-add.

Top module: `bw_alu_flags`

## Requirements
- R1: After reset all six status bits read 0.
- R2: Opcodes 0 (a+b), 1 (a+b+carry), 2 (a-b), 3 (a-b-carry) give the result modulo 2^width; carry is the unsigned carry out, or for 2 and 3 the borrow (set when the subtrahend plus incoming carry exceeds `src_a` unsigned); in byte mode result bits 15:8 equal `src_a[15:8]`.
- R3: For every flag-writing operation except NOT and the unpacked adjust, parity (bit 1) is 1 when result bits 7:0 hold an even number of ones; zero (bit 3) and sign (bit 4) are taken at the operand width.
- R4: For opcodes 0 to 7, half carry (bit 2) is the carry or borrow out of bit 3 and overflow (bit 5) is signed overflow at the operand width.
- R5: Increment (5) and decrement (6) add or subtract one and leave carry unchanged; incrementing byte FFh yields 00h with carry still at its old value.
- R6: Compare (4) sets flags exactly as subtract and test (12) exactly as AND, and neither raises `res_wr`; every other opcode raises `res_wr` when `op_valid` is high.
- R7: AND (8), OR (9), XOR (10) and test (12) clear carry and overflow and keep half carry unchanged.
- R8: NOT (11) returns the bitwise complement at the operand width and changes no flag.
- R9: Negate (7) returns 0 minus the operand; carry is set when the operand is non-zero and overflow is set for byte 80h or word 8000h.
- R10: Decimal adjust after add (13) adds 06h when the low nibble exceeds 9 or half carry is set (setting half carry, else clearing it), then adds 60h and sets carry when the original byte exceeds 99h or carry was set (else clears carry); opcode 14 subtracts under the same conditions; overflow is kept; 59h+35h then opcode 13 gives 94h.
- R11: Unpacked adjust (15): when the low nibble of bits 7:0 exceeds 9 or half carry is set, it adds 6 to bits 7:0, adds 1 to bits 15:8 and sets carry and half carry, else clears both; bits 7:4 of the result are 0; overflow, sign, zero and parity are kept; 6Eh gives low byte 04h with carry 1.
- R12: The status register changes only at a clock edge where `op_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle; loads the status register at the edge |
| op_code | input | 4 | Operation select (encoding above) |
| wide | input | 1 | 1 = 16-bit operands, 0 = 8-bit |
| src_a | input | 16 | Destination operand |
| src_b | input | 16 | Source operand |
| result | output | 16 | Combinational result |
| res_wr | output | 1 | Result is to be written back |
| flags | output | 6 | Status register {of, sf, zf, af, pf, cf} |

## Verification
`result` and `res_wr` are due in the same cycle the inputs are applied, so the bench drives on the falling edge and samples them one nanosecond later, before the rising edge. The flag word is due one edge later: the bench samples it one nanosecond after the rising edge that closed the operation, compares it with its own running model, and only then applies the next stimulus. Idle cycles are checked the same way to show the register is held.

// File: rtl/bwalu_pkg.sv
package bwalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_CMP  = 4'd4,
        OP_INC  = 4'd5,
        OP_DEC  = 4'd6,
        OP_NEG  = 4'd7,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_NOT  = 4'd11,
        OP_TEST = 4'd12,
        OP_DADD = 4'd13,
        OP_DSUB = 4'd14,
        OP_UADD = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic of_f;
        logic sf_f;
        logic zf_f;
        logic af_f;
        logic pf_f;
        logic cf_f;
    } alu_flags_t;

endpackage

// File: rtl/bwalu_addsub.sv
module bwalu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         co,
    output logic         hc,
    output logic         ov
);
    localparam int MSB = W - 1;

    logic [W:0] ext;

    always_comb begin
        if (sub) ext = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        else     ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end

    assign r  = ext[W-1:0];
    assign co = ext[W];
    assign hc = a[4] ^ b[4] ^ r[4];
    assign ov = sub ? ((a[MSB] != b[MSB]) && (r[MSB] != a[MSB]))
                    : ((a[MSB] == b[MSB]) && (r[MSB] != a[MSB]));
endmodule

// File: rtl/bwalu_logic.sv
module bwalu_logic #(
    parameter int W = 16
) (
    input  bwalu_pkg::alu_op_e op,
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    output logic [W-1:0]       r
);
    import bwalu_pkg::*;

    always_comb begin
        unique case (op)
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_NOT:  r = ~a;
            default: r = a & b;
        endcase
    end
endmodule

// File: rtl/bwalu_bcd.sv
module bwalu_bcd #(
    parameter int W = 16
) (
    input  bwalu_pkg::alu_op_e op,
    input  logic [W-1:0]       a,
    input  logic               cf_in,
    input  logic               af_in,
    output logic [W-1:0]       r,
    output logic               cf_out,
    output logic               af_out
);
    import bwalu_pkg::*;

    localparam int HB = W / 2;

    logic [7:0]    lo;
    logic [HB-1:0] hi;
    logic          fix_lo;
    logic          fix_hi;
    logic [7:0]    step;

    assign lo     = a[7:0];
    assign hi     = a[W-1:HB];
    assign fix_lo = (lo[3:0] > 4'd9) || af_in;
    assign fix_hi = (lo > 8'h99) || cf_in;

    always_comb begin
        r      = a;
        cf_out = cf_in;
        af_out = fix_lo;
        step   = lo;
        unique case (op)
            OP_DADD: begin
                step   = fix_lo ? lo + 8'h06 : lo;
                r      = {hi, fix_hi ? step + 8'h60 : step};
                cf_out = fix_hi;
            end
            OP_DSUB: begin
                step   = fix_lo ? lo - 8'h06 : lo;
                r      = {hi, fix_hi ? step - 8'h60 : step};
                cf_out = fix_hi;
            end
            default: begin
                step   = fix_lo ? lo + 8'h06 : lo;
                r      = {fix_lo ? hi + {{(HB-1){1'b0}}, 1'b1} : hi, 4'h0, step[3:0]};
                cf_out = fix_lo;
            end
        endcase
    end
endmodule

// File: rtl/bw_alu_flags.sv
module bw_alu_flags #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic              wide,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    output logic [WORD_W-1:0] result,
    output logic              res_wr,
    output logic [5:0]        flags
);
    import bwalu_pkg::*;

    localparam int HALF_W = WORD_W / 2;

    alu_op_e    op;
    alu_flags_t flag_q;
    alu_flags_t flag_d;

    assign op    = alu_op_e'(op_code);
    assign flags = flag_q;

    // operand steering for the add/subtract cores
    logic [WORD_W-1:0] core_a, core_b;
    logic              core_cin, core_sub;

    always_comb begin
        core_a   = src_a;
        core_b   = src_b;
        core_cin = 1'b0;
        core_sub = 1'b0;
        unique case (op)
            OP_ADC:         core_cin = flag_q.cf_f;
            OP_SUB, OP_CMP: core_sub = 1'b1;
            OP_SBB: begin core_sub = 1'b1; core_cin = flag_q.cf_f; end
            OP_INC:         core_b = {{(WORD_W-1){1'b0}}, 1'b1};
            OP_DEC: begin core_sub = 1'b1; core_b = {{(WORD_W-1){1'b0}}, 1'b1}; end
            OP_NEG: begin core_sub = 1'b1; core_a = '0; core_b = src_a; end
            default: ;
        endcase
    end

    logic [WORD_W-1:0] w_r;
    logic [HALF_W-1:0] b_r;
    logic w_co, w_hc, w_ov, b_co, b_hc, b_ov;

    bwalu_addsub #(.W(WORD_W)) i_core_word (
        .a(core_a), .b(core_b), .cin(core_cin), .sub(core_sub),
        .r(w_r), .co(w_co), .hc(w_hc), .ov(w_ov)
    );

    bwalu_addsub #(.W(HALF_W)) i_core_byte (
        .a(core_a[HALF_W-1:0]), .b(core_b[HALF_W-1:0]), .cin(core_cin), .sub(core_sub),
        .r(b_r), .co(b_co), .hc(b_hc), .ov(b_ov)
    );

    logic [WORD_W-1:0] lg_r;

    bwalu_logic #(.W(WORD_W)) i_logic (
        .op(op), .a(src_a), .b(src_b), .r(lg_r)
    );

    logic [WORD_W-1:0] bcd_r;
    logic              bcd_cf, bcd_af;

    bwalu_bcd #(.W(WORD_W)) i_bcd (
        .op(op), .a(src_a), .cf_in(flag_q.cf_f), .af_in(flag_q.af_f),
        .r(bcd_r), .cf_out(bcd_cf), .af_out(bcd_af)
    );

    // result selection and width merge
    logic [WORD_W-1:0] ar_full, lg_full;
    logic              is_arith, is_logic, is_bcd;
    logic              ar_co, ar_hc, ar_ov;

    assign is_arith = (op_code <= 4'd7);
    assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
                      (op == OP_TEST) || (op == OP_NOT);
    assign is_bcd   = (op == OP_DADD) || (op == OP_DSUB) || (op == OP_UADD);

    assign ar_full = wide ? w_r : {src_a[WORD_W-1:HALF_W], b_r};
    assign lg_full = wide ? lg_r : {src_a[WORD_W-1:HALF_W], lg_r[HALF_W-1:0]};
    assign ar_co   = wide ? w_co : b_co;
    assign ar_hc   = wide ? w_hc : b_hc;
    assign ar_ov   = wide ? w_ov : b_ov;

    always_comb begin
        if (is_arith)      result = ar_full;
        else if (is_logic) result = lg_full;
        else               result = bcd_r;
    end

    assign res_wr = op_valid && (op != OP_CMP) && (op != OP_TEST);

    // flag policy per operation
    logic res_zero, res_sign, res_par;
    logic wide_eff;

    assign wide_eff = wide && !is_bcd;
    assign res_zero = wide_eff ? (result == '0) : (result[HALF_W-1:0] == '0);
    assign res_sign = wide_eff ? result[WORD_W-1] : result[HALF_W-1];
    assign res_par  = ~^result[7:0];

    always_comb begin
        flag_d = flag_q;
        if (is_arith) begin
            flag_d.cf_f = ((op == OP_INC) || (op == OP_DEC)) ? flag_q.cf_f : ar_co;
            flag_d.af_f = ar_hc;
            flag_d.of_f = ar_ov;
            flag_d.zf_f = res_zero;
            flag_d.sf_f = res_sign;
            flag_d.pf_f = res_par;
        end else if (is_logic && (op != OP_NOT)) begin
            flag_d.cf_f = 1'b0;
            flag_d.of_f = 1'b0;
            flag_d.zf_f = res_zero;
            flag_d.sf_f = res_sign;
            flag_d.pf_f = res_par;
        end else if (is_bcd) begin
            flag_d.cf_f = bcd_cf;
            flag_d.af_f = bcd_af;
            if (op != OP_UADD) begin
                flag_d.zf_f = res_zero;
                flag_d.sf_f = res_sign;
                flag_d.pf_f = res_par;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= '0;
        else if (op_valid) flag_q <= flag_d;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags)); // R12
    AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code == 4'd5 || op_code == 4'd6) |=> flags[0] == $past(flags[0])); // R5
    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code == 4'd8 || op_code == 4'd9 || op_code == 4'd10 || op_code == 4'd12)
        |=> !flags[0] && !flags[5] && flags[2] == $past(flags[2])); // R7
    AST_NOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 4'd11 |=> $stable(flags)); // R8
    AST_ADD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 4'd0 |=> flags[1] == ~^$past(result[7:0])); // R3
    AST_NEG_MIN_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 4'd7 && !wide && src_a[7:0] == 8'h80 |=> flags[5]); // R9
endmodule

// File: tb/test_bw_alu_flags.sv
module test_bw_alu_flags;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic        wide = 1'b0;
    logic [15:0] src_a = 16'h0;
    logic [15:0] src_b = 16'h0;
    logic [15:0] result;
    logic        res_wr;
    logic [5:0]  flags;

    int checks = 0;
    int errors = 0;
    logic [5:0] exp_fl = 6'h0;

    always #2 clk = ~clk;

    bw_alu_flags i_bw_alu_flags (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .wide(wide), .src_a(src_a), .src_b(src_b),
        .result(result), .res_wr(res_wr), .flags(flags)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic even_ones(int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return (n % 2) == 0;
    endfunction

    function automatic string tag_of(int op);
        if (op <= 3)       return "R2";
        if (op == 4)       return "R6";
        if (op <= 6)       return "R5";
        if (op == 7)       return "R9";
        if (op == 11)      return "R8";
        if (op == 12)      return "R6";
        if (op <= 10)      return "R7";
        if (op <= 14)      return "R10";
        return "R11";
    endfunction

    // reference model, written from the requirements
    task automatic model(input int op, input bit w, input int a, input int b,
                         input logic [5:0] fi, output int r, output bit wr,
                         output logic [5:0] fo);
        int mask = w ? 'hFFFF : 'hFF;
        int half = (mask + 1) / 2;
        bit cf = fi[0], pf = fi[1], af = fi[2], zf = fi[3], sf = fi[4], of_ = fi[5];
        int x, y, c, full, nib, sx, sy, sfull, lo, hi, st;
        bit issub;
        wr = !(op == 4 || op == 12);
        r  = a;
        if (op <= 7) begin
            x = a & mask; y = b & mask; c = 0; issub = 0;
            case (op)
                1: c = cf;
                2, 4: issub = 1;
                3: begin issub = 1; c = cf; end
                5: y = 1;
                6: begin y = 1; issub = 1; end
                7: begin x = 0; y = a & mask; issub = 1; end
                default: ;
            endcase
            full = issub ? x - y - c : x + y + c;
            nib  = issub ? (x & 15) - (y & 15) - c : (x & 15) + (y & 15) + c;
            sx = (x >= half) ? x - mask - 1 : x;
            sy = (y >= half) ? y - mask - 1 : y;
            sfull = issub ? sx - sy - c : sx + sy + c;
            r = w ? (full & mask) : ((a & 'hFF00) | (full & mask));
            if (op != 5 && op != 6) cf = issub ? (full < 0) : (full > mask);
            af  = issub ? (nib < 0) : (nib > 15);
            of_ = (sfull >= half) || (sfull < -half);
            zf = (r & mask) == 0; sf = ((r & mask) >= half); pf = even_ones(r);
        end else if (op <= 12) begin
            case (op)
                9:  x = a | b;
                10: x = a ^ b;
                11: x = ~a;
                default: x = a & b;
            endcase
            r = w ? (x & mask) : ((a & 'hFF00) | (x & 'hFF));
            if (op != 11) begin
                cf = 0; of_ = 0;
                zf = (r & mask) == 0; sf = ((r & mask) >= half); pf = even_ones(r);
            end
        end else begin
            lo = a & 'hFF; hi = (a >> 8) & 'hFF;
            if (op == 15) begin
                if ((lo & 15) > 9 || af) begin
                    lo = (lo + 6) & 'hFF; hi = (hi + 1) & 'hFF; af = 1; cf = 1;
                end else begin af = 0; cf = 0; end
                r = (hi << 8) | (lo & 15);
            end else begin
                st = lo;
                if ((lo & 15) > 9 || af) begin
                    st = (op == 13) ? st + 6 : st - 6; af = 1;
                end else af = 0;
                if (lo > 'h99 || cf) begin
                    st = (op == 13) ? st + 'h60 : st - 'h60; cf = 1;
                end else cf = 0;
                r = (hi << 8) | (st & 'hFF);
                zf = (st & 'hFF) == 0; sf = (st & 'h80) != 0; pf = even_ones(st);
            end
        end
        fo = {of_, sf, zf, af, pf, cf};
    endtask

    task automatic run_op(int op, bit w, int a, int b);
        int er; bit ewr; logic [5:0] ef;
        string t = tag_of(op);
        op_code = op[3:0]; wide = w; src_a = a[15:0]; src_b = b[15:0]; op_valid = 1'b1;
        model(op, w, a & 'hFFFF, b & 'hFFFF, exp_fl, er, ewr, ef);
        #1;
        check(ewr ? t : "R6", int'(res_wr), int'(ewr));
        if (ewr || op == 4 || op == 12) check(t, int'(result), er);
        @(posedge clk); #1;
        op_valid = 1'b0;
        check(op <= 7 ? "R4" : t, int'(flags), int'(ef));
        exp_fl = ef;
        @(negedge clk);
    endtask

    task automatic run_idle(int a, int b);
        op_valid = 1'b0; op_code = a[3:0]; src_a = a[15:0]; src_b = b[15:0];
        @(posedge clk); #1;
        check("R12", int'(flags), int'(exp_fl));
        @(negedge clk);
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5A17);
        repeat (3) @(negedge clk);
        check("R1", int'(flags), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(flags), 0);

        // directed corners
        run_op(0, 0, 'h12FF, 'h0001);   // R2 carry out, upper byte kept
        run_op(5, 0, 'h00FF, 0);        // R5 FF -> 00, carry held at 1
        run_op(8, 0, 'h0F0F, 'h00F0);   // R7 clears carry
        run_op(5, 0, 'h00FF, 0);        // R5 carry held at 0
        run_op(7, 0, 'h0080, 0);        // R9 overflow
        run_op(7, 1, 'h8000, 0);        // R9 word
        run_op(7, 1, 'h0000, 0);        // R9 zero: no carry
        run_op(4, 1, 'h0010, 'h0020);   // R6 compare borrow
        run_op(12, 1, 'h8000, 'h8001);  // R6 test
        run_op(11, 1, 'h1234, 0);       // R8
        run_op(0, 0, 'h0059, 'h0035);   // R10 setup 8E
        run_op(13, 0, 'h008E, 0);       // R10 -> 94
        run_op(2, 0, 'h0022, 'h0017);   // R10 setup
        run_op(14, 0, 'h000B, 0);       // R10 subtract adjust
        run_op(0, 0, 'h0035, 'h0039);   // R11 setup 6E
        run_op(15, 0, 'h006E, 0);       // R11 -> 0104, carry 1
        run_op(0, 1, 'h7FFF, 'h0001);   // R4 signed overflow word
        run_op(3, 1, 'h0000, 'h0000);   // R2 borrow chain
        run_idle('h1111, 'h2222);

        for (int k = 0; k < 600; k++) begin
            if ($urandom_range(0, 9) == 0) run_idle($urandom, $urandom);
            else run_op($urandom_range(0, 15), $urandom_range(0, 1), $urandom, $urandom);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule